// File: doc/BRIEF.md
# Register Writer Table with Writer History

This block records, for every architectural register, which function unit is the newest in issue order that will write it. Each register row is a short stack of one-hot slots. Slot 0 holds the current writer. The slots behind it hold earlier writers that are still pending. A result that a newer issue has overwritten then does not have to reach the register file. A unit that sits in any history slot is reported as barred from committing.

The issue logic presents a destination register and a one-hot unit on each accepted issue. The block pushes that unit into the row and moves the previous writers one slot deeper. If the row already holds the maximum number of earlier writers, the block raises a busy flag and the issue has no effect. A per-unit done mask removes finished or dropped units from every slot, and the older entries close up toward slot 0. A rollback request carries a one-hot mask of cancelled units and completes in one cycle. Every row whose current writer was cancelled reverts to its newest surviving earlier writer. That writer is reported for one cycle so the exception sequencer can have it store its result before the exception goes ahead. Issue is ignored in a rollback cycle.

Top module: `wrtab_top`

## Requirements
- R1: After reset every row is empty: `cur_writer`, `hold_commit`, `rb_writer` and `flush_fu` are all zero, and `iss_busy` is low while `iss_valid` is low.
- R2: An accepted issue (`iss_valid` high, `rb_valid` low, `iss_busy` low) makes row `iss_reg` of `cur_writer` (bits `iss_reg*NUM_FU` upward, bit i meaning unit i) equal to `iss_fu` from the next cycle on. Other rows are unchanged.
- R3: An accepted issue to a row that already has a current writer moves that writer into history, and its bit in `hold_commit` is set from the next cycle.
- R4: `iss_busy` is high in the same cycle whenever `iss_valid` is high and the addressed row already holds `HIST_DEPTH` earlier writers behind its current one. Such an issue leaves the table unchanged.
- R5: A unit set in `done_mask` is cleared from every slot of every row by the next cycle. The remaining entries keep their order and close up toward the current slot, so removing the current writer promotes the newest earlier writer.
- R6: With `rb_valid` high, every unit in `rb_cancel` is removed from all slots in that single cycle. Each affected row reverts to its newest non-cancelled earlier writer.
- R7: In the cycle after a rollback, `rb_writer` shows, for each row whose current writer was cancelled, the writer that became current (zero if none remains), and `flush_fu` is the OR of those rows. Both are zero in all other cycles.
- R8: An issue presented in a rollback cycle has no effect on any row.
- R9: Each row of `cur_writer` has at most one bit set at all times.
- R10: `hold_commit` bit i is set exactly when unit i occupies a history slot of some row. It drops once the unit is promoted to current or removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request present |
| iss_reg | input | RW = clog2(NUM_REGS) | Destination register of the issue |
| iss_fu | input | NUM_FU | One-hot unit being issued |
| iss_busy | output | 1 | Addressed row has full history; issue stalls |
| done_mask | input | NUM_FU | Units whose results were committed or dropped |
| rb_valid | input | 1 | Rollback request |
| rb_cancel | input | NUM_FU | One-hot mask of cancelled units |
| cur_writer | output | NUM_REGS*NUM_FU | Current writer of each row, one-hot |
| hold_commit | output | NUM_FU | Unit is in a history slot and must not commit |
| rb_writer | output | NUM_REGS*NUM_FU | Writer restored per row by the last rollback |
| flush_fu | output | NUM_FU | Units that must store their result after rollback |

## Verification
`iss_busy` is combinational and is due in the same cycle that the issue is presented. The table contents, `hold_commit`, `rb_writer` and `flush_fu` come from registers and change at the first rising edge after the stimulus. The bench drives inputs on the falling edge and reads `iss_busy` one nanosecond later. It compares every registered output at the following falling edge against a stack model kept in the bench and advanced once per edge. A directed run covers each ordering case, and a long pseudo-random sweep then mixes issues, done masks and rollbacks over a four-register, four-unit table.

// File: rtl/wrtab_pkg.sv
package wrtab_pkg;

   // Per-row update chosen each cycle
   typedef enum logic [1:0] {
      ROW_KEEP  = 2'd0,   // nothing touches this row
      ROW_SHIFT = 2'd1,   // entries removed, survivors close up
      ROW_PUSH  = 2'd2    // new writer enters slot 0
   } row_op_e;

endpackage

// File: rtl/wrtab_issue.sv
module wrtab_issue #(
   parameter int NUM_REGS = 8,
   parameter int RW       = 3
) (
   input  logic                iss_valid,
   input  logic [RW-1:0]       iss_reg,
   input  logic                rb_valid,
   input  logic [NUM_REGS-1:0] row_full,
   output logic [NUM_REGS-1:0] push_vec,
   output logic                iss_busy
);

   logic [NUM_REGS-1:0] sel;
   logic                sel_full;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_dec
      assign sel[r] = (iss_reg == RW'(r));
   end

   assign sel_full = |(sel & row_full);
   assign iss_busy = iss_valid && sel_full;

   always_comb begin
      if (iss_valid && !rb_valid && !sel_full) push_vec = sel;
      else                                     push_vec = '0;
   end

endmodule

// File: rtl/wrtab_or_reduce.sv
module wrtab_or_reduce #(
   parameter int NUM_ROWS = 8,
   parameter int WIDTH    = 4
) (
   input  logic [NUM_ROWS*WIDTH-1:0] rows_flat,
   output logic [WIDTH-1:0]          merged
);

   always_comb begin
      merged = '0;
      for (int r = 0; r < NUM_ROWS; r++) merged |= rows_flat[r*WIDTH +: WIDTH];
   end

endmodule

// File: rtl/wrtab_row.sv
module wrtab_row
   import wrtab_pkg::*;
#(
   parameter int NUM_FU     = 4,
   parameter int HIST_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_FU-1:0] remove_mask,
   input  logic [NUM_FU-1:0] cancel_mask,
   input  logic              rb_active,
   input  logic              push_en,
   input  logic [NUM_FU-1:0] push_fu,
   output logic [NUM_FU-1:0] cur_fu,
   output logic [NUM_FU-1:0] hist_fu,
   output logic [NUM_FU-1:0] revert_fu,
   output logic              full
);

   localparam int SLOTS = HIST_DEPTH + 1;

   logic [NUM_FU-1:0] slot_q   [SLOTS];
   logic [NUM_FU-1:0] kept     [SLOTS];
   logic [NUM_FU-1:0] packed_s [SLOTS];
   logic [NUM_FU-1:0] slot_d   [SLOTS];
   logic [NUM_FU-1:0] revert_q;
   logic              any_removed;
   logic              cur_cancelled;
   row_op_e           op;

   // strip removed units from every slot
   always_comb begin
      any_removed = 1'b0;
      for (int k = 0; k < SLOTS; k++) begin
         kept[k]     = slot_q[k] & ~remove_mask;
         any_removed = any_removed | (|(slot_q[k] & remove_mask));
      end
   end

   if (HIST_DEPTH == 0) begin : g_flat
      always_comb packed_s[0] = kept[0];
      assign hist_fu = '0;
   end else begin : g_stack
      // stable compaction: k-th surviving entry goes to slot k
      always_comb begin
         int pos;
         pos = 0;
         for (int k = 0; k < SLOTS; k++) packed_s[k] = '0;
         for (int k = 0; k < SLOTS; k++) begin
            for (int j = 0; j < SLOTS; j++) begin
               if ((pos == j) && (|kept[k])) packed_s[j] = kept[k];
            end
            if (|kept[k]) pos = pos + 1;
         end
      end

      always_comb begin
         hist_fu = '0;
         for (int k = 1; k < SLOTS; k++) hist_fu |= slot_q[k];
      end
   end

   always_comb begin
      if (push_en)          op = ROW_PUSH;
      else if (any_removed) op = ROW_SHIFT;
      else                  op = ROW_KEEP;
   end

   always_comb begin
      case (op)
         ROW_PUSH: begin
            slot_d[0] = push_fu;
            for (int k = 1; k < SLOTS; k++) slot_d[k] = packed_s[k-1];
         end
         ROW_SHIFT: begin
            for (int k = 0; k < SLOTS; k++) slot_d[k] = packed_s[k];
         end
         default: begin
            for (int k = 0; k < SLOTS; k++) slot_d[k] = slot_q[k];
         end
      endcase
   end

   assign cur_cancelled = rb_active && (|(slot_q[0] & cancel_mask));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < SLOTS; k++) slot_q[k] <= '0;
         revert_q <= '0;
      end else begin
         for (int k = 0; k < SLOTS; k++) slot_q[k] <= slot_d[k];
         revert_q <= cur_cancelled ? packed_s[0] : '0;
      end
   end

   assign cur_fu    = slot_q[0];
   assign full      = |slot_q[HIST_DEPTH];
   assign revert_fu = revert_q;

endmodule

// File: rtl/wrtab_top.sv
module wrtab_top #(
   parameter int NUM_REGS   = 8,
   parameter int NUM_FU     = 4,
   parameter int HIST_DEPTH = 2,
   localparam int RW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       iss_valid,
   input  logic [RW-1:0]              iss_reg,
   input  logic [NUM_FU-1:0]          iss_fu,
   output logic                       iss_busy,
   input  logic [NUM_FU-1:0]          done_mask,
   input  logic                       rb_valid,
   input  logic [NUM_FU-1:0]          rb_cancel,
   output logic [NUM_REGS*NUM_FU-1:0] cur_writer,
   output logic [NUM_FU-1:0]          hold_commit,
   output logic [NUM_REGS*NUM_FU-1:0] rb_writer,
   output logic [NUM_FU-1:0]          flush_fu
);

   localparam int FLAT_W = NUM_REGS * NUM_FU;

   if (NUM_REGS < 2) begin : g_bad_regs
      $error("wrtab_top: NUM_REGS must be at least 2");
   end
   if (NUM_FU < 2) begin : g_bad_fu
      $error("wrtab_top: NUM_FU must be at least 2");
   end
   if (HIST_DEPTH < 0) begin : g_bad_depth
      $error("wrtab_top: HIST_DEPTH must not be negative");
   end

   logic [NUM_REGS-1:0] row_full;
   logic [NUM_REGS-1:0] push_vec;
   logic [NUM_FU-1:0]   remove_mask;
   logic [NUM_FU-1:0]   cancel_mask;
   logic [FLAT_W-1:0]   hist_flat;

   assign cancel_mask = rb_valid ? rb_cancel : '0;
   assign remove_mask = done_mask | cancel_mask;

   wrtab_issue #(
      .NUM_REGS (NUM_REGS),
      .RW       (RW)
   ) u_issue (
      .iss_valid (iss_valid),
      .iss_reg   (iss_reg),
      .rb_valid  (rb_valid),
      .row_full  (row_full),
      .push_vec  (push_vec),
      .iss_busy  (iss_busy)
   );

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
      wrtab_row #(
         .NUM_FU     (NUM_FU),
         .HIST_DEPTH (HIST_DEPTH)
      ) u_row (
         .clk         (clk),
         .rst_n       (rst_n),
         .remove_mask (remove_mask),
         .cancel_mask (cancel_mask),
         .rb_active   (rb_valid),
         .push_en     (push_vec[r]),
         .push_fu     (iss_fu),
         .cur_fu      (cur_writer[r*NUM_FU +: NUM_FU]),
         .hist_fu     (hist_flat[r*NUM_FU +: NUM_FU]),
         .revert_fu   (rb_writer[r*NUM_FU +: NUM_FU]),
         .full        (row_full[r])
      );
   end

   wrtab_or_reduce #(
      .NUM_ROWS (NUM_REGS),
      .WIDTH    (NUM_FU)
   ) u_hold (
      .rows_flat (hist_flat),
      .merged    (hold_commit)
   );

   wrtab_or_reduce #(
      .NUM_ROWS (NUM_REGS),
      .WIDTH    (NUM_FU)
   ) u_flush (
      .rows_flat (rb_writer),
      .merged    (flush_fu)
   );

endmodule

// File: rtl/wrtab_chk.sv
module wrtab_chk #(
   parameter int NUM_REGS   = 8,
   parameter int NUM_FU     = 4,
   parameter int HIST_DEPTH = 2,
   localparam int RW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       iss_valid,
   input logic [RW-1:0]              iss_reg,
   input logic [NUM_FU-1:0]          iss_fu,
   input logic                       iss_busy,
   input logic [NUM_FU-1:0]          done_mask,
   input logic                       rb_valid,
   input logic [NUM_FU-1:0]          rb_cancel,
   input logic [NUM_REGS*NUM_FU-1:0] cur_writer,
   input logic [NUM_FU-1:0]          hold_commit,
   input logic [NUM_REGS*NUM_FU-1:0] rb_writer,
   input logic [NUM_FU-1:0]          flush_fu
);

   logic              pr_push;
   logic [RW-1:0]     pr_reg;
   logic [NUM_FU-1:0] pr_fu;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pr_push <= 1'b0;
         pr_reg  <= '0;
         pr_fu   <= '0;
      end else begin
         pr_push <= iss_valid && !iss_busy && !rb_valid;
         pr_reg  <= iss_reg;
         pr_fu   <= iss_fu;
      end
   end

   // R4: busy is only raised for a presented issue
   p_busy_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      iss_busy |-> iss_valid);

   // R2: an accepted issue shows up as the row's current writer
   p_issue_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pr_push |-> (cur_writer[int'(pr_reg)*NUM_FU +: NUM_FU] == pr_fu));

   // R5: a finished unit is no longer held in history
   p_done_not_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|done_mask) |=> ((hold_commit & $past(done_mask)) == '0));

   // R7: restore report only follows a rollback
   p_flush_after_rb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rb_valid |=> (rb_writer == '0) && (flush_fu == '0));

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_rowchk
      // R9: one writer at most per row
      p_cur_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(cur_writer[r*NUM_FU +: NUM_FU]));

      // R6: cancelled units never remain current
      p_cancel_gone_r6: assert property (@(posedge clk) disable iff (!rst_n)
         rb_valid |=> ((cur_writer[r*NUM_FU +: NUM_FU] & $past(rb_cancel)) == '0));
   end

endmodule

bind wrtab_top wrtab_chk #(
   .NUM_REGS   (NUM_REGS),
   .NUM_FU     (NUM_FU),
   .HIST_DEPTH (HIST_DEPTH)
) u_chk (.*);

// File: tb/tb_wrtab_top.sv
module tb_wrtab_top;

   localparam int CLK_PERIOD = 10;
   localparam int NR = 4;
   localparam int NF = 4;
   localparam int HD = 2;
   localparam int RW = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              iss_valid = 1'b0;
   logic [RW-1:0]     iss_reg = '0;
   logic [NF-1:0]     iss_fu = '0;
   logic              iss_busy;
   logic [NF-1:0]     done_mask = '0;
   logic              rb_valid = 1'b0;
   logic [NF-1:0]     rb_cancel = '0;
   logic [NR*NF-1:0]  cur_writer;
   logic [NF-1:0]     hold_commit;
   logic [NR*NF-1:0]  rb_writer;
   logic [NF-1:0]     flush_fu;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;
   string last_tag = "R1";

   // bench model: unit index per slot, -1 = empty
   int stk [NR][HD+1];
   int rbw_m [NR];

   always #(CLK_PERIOD/2) clk = ~clk;

   wrtab_top #(.NUM_REGS(NR), .NUM_FU(NF), .HIST_DEPTH(HD)) dut (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_reg(iss_reg),
      .iss_fu(iss_fu), .iss_busy(iss_busy), .done_mask(done_mask),
      .rb_valid(rb_valid), .rb_cancel(rb_cancel), .cur_writer(cur_writer),
      .hold_commit(hold_commit), .rb_writer(rb_writer), .flush_fu(flush_fu)
   );

   function automatic logic [NF-1:0] oh(int f);
      return (f < 0) ? '0 : NF'(1 << f);
   endfunction

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_state(string tag);
      logic [NR*NF-1:0] e_cur, e_rbw;
      logic [NF-1:0]    e_hold, e_flush;
      e_cur = '0; e_rbw = '0; e_hold = '0; e_flush = '0;
      for (int r = 0; r < NR; r++) begin
         e_cur[r*NF +: NF] = oh(stk[r][0]);
         e_rbw[r*NF +: NF] = oh(rbw_m[r]);
         e_flush |= oh(rbw_m[r]);
         for (int k = 1; k <= HD; k++) e_hold |= oh(stk[r][k]);
      end
      chk(tag, "cur_writer", 64'(cur_writer), 64'(e_cur));
      chk(tag, "hold_commit", 64'(hold_commit), 64'(e_hold));
      chk(tag, "rb_writer", 64'(rb_writer), 64'(e_rbw));
      chk(tag, "flush_fu", 64'(flush_fu), 64'(e_flush));
   endtask

   task automatic model_step(bit iv, int rg, int fu, logic [NF-1:0] done,
                             bit rbv, logic [NF-1:0] rbc);
      logic [NF-1:0] rem;
      bit accept;
      int tmp [HD+1];
      rem = done | (rbv ? rbc : '0);
      accept = iv && !rbv && (stk[rg][HD] < 0);
      for (int r = 0; r < NR; r++) begin
         int cnt;
         cnt = 0;
         for (int k = 0; k <= HD; k++) tmp[k] = -1;
         for (int k = 0; k <= HD; k++) begin
            if (stk[r][k] >= 0 && !rem[stk[r][k]]) begin
               tmp[cnt] = stk[r][k];
               cnt++;
            end
         end
         if (rbv && stk[r][0] >= 0 && rbc[stk[r][0]]) rbw_m[r] = tmp[0];
         else                                          rbw_m[r] = -1;
         if (accept && r == rg) begin
            stk[r][0] = fu;
            for (int k = 1; k <= HD; k++) stk[r][k] = tmp[k-1];
         end else begin
            for (int k = 0; k <= HD; k++) stk[r][k] = tmp[k];
         end
      end
   endtask

   task automatic step(string tag, bit iv, int rg, int fu, logic [NF-1:0] done,
                       bit rbv, logic [NF-1:0] rbc);
      @(negedge clk);
      check_state(last_tag);
      iss_valid = iv;
      iss_reg   = RW'(rg);
      iss_fu    = oh(fu);
      done_mask = done;
      rb_valid  = rbv;
      rb_cancel = rbc;
      #1;
      chk(tag, "iss_busy", 64'(iss_busy), 64'(iv && (stk[rg][HD] >= 0)));
      model_step(iv, rg, fu, done, rbv, rbc);
      last_tag = tag;
   endtask

   initial begin
      for (int r = 0; r < NR; r++) begin
         rbw_m[r] = -1;
         for (int k = 0; k <= HD; k++) stk[r][k] = -1;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: empty after reset (checked at the next step's falling edge)
      step("R1", 1'b0, 0, 0, '0, 1'b0, '0);
      // R2: first writer of register 1 is unit 0
      step("R2", 1'b1, 1, 0, '0, 1'b0, '0);
      // R3: unit 1 overwrites, unit 0 goes to history
      step("R3", 1'b1, 1, 1, '0, 1'b0, '0);
      step("R3", 1'b1, 1, 2, '0, 1'b0, '0);
      // R4: history full, issue of unit 3 stalls
      step("R4", 1'b1, 1, 3, '0, 1'b0, '0);
      step("R4", 1'b0, 1, 0, '0, 1'b0, '0);
      // R5 and R10: unit 2 done, unit 1 promoted and no longer held
      step("R5", 1'b0, 0, 0, 4'b0100, 1'b0, '0);
      step("R10", 1'b0, 0, 0, '0, 1'b0, '0);
      // R8: issue during rollback is ignored
      step("R8", 1'b1, 2, 3, '0, 1'b1, 4'b1000);
      // R6 and R7: refill, then cancel units 2 and 1
      step("R2", 1'b1, 1, 2, '0, 1'b0, '0);
      step("R6", 1'b0, 0, 0, '0, 1'b1, 4'b0110);
      step("R7", 1'b0, 0, 0, '0, 1'b0, '0);
      // R10: unit 0 is current again and not held
      step("R10", 1'b1, 3, 2, '0, 1'b0, '0);
      step("R5", 1'b0, 0, 0, 4'b0001, 1'b0, '0);

      // sweep: mixed traffic against the model
      begin
         logic [31:0] lf;
         lf = 32'h1357_9bdf;
         for (int i = 0; i < 4000; i++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            step("R9", lf[0] | lf[22], int'(lf[2:1]), int'(lf[4:3]),
                 lf[8:5] & lf[20:17], (lf[11:9] == 3'd0), lf[15:12]);
         end
      end
      @(negedge clk);
      check_state(last_tag);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule